// File: doc/BRIEF.md
# Hardwired Instruction Control Sequencer

This block is the control section of a small 16-bit accumulator processor. It does not use a stored microprogram. Its strobes come from two sources: a binary step counter, decoded into one-hot timing lines, and a one-hot decode of the instruction's operation field. Each strobe is a short product of a timing line, an operation line, the addressing-mode bit, status flags and the interrupt request. The datapath, the ALU and the memory sit outside the block. They see only the strobes, together with the address field of the held instruction.

Every instruction starts with a fetch. The program counter is sent to the address register. The word on the memory read bus is then loaded into the instruction register while the program counter steps. A decode step follows, and after it come execute steps whose length depends on the operation group. An interrupt request seen at the first step of an instruction replaces the fetch with a two-step interrupt entry. A halt instruction parks the block until a restart command arrives.

Top module: `hwseq_ctrl`

## Requirements
- R1: The instruction register loads `mem_rdata` at the end of step T1, and `addr_field` shows its bits 11:0 from the next cycle. At the end of T2, `op_line` becomes the one-hot decode of bits 14:12 (bit k set for operation code k) and `ind_bit` takes bit 15. Both hold until the next T2.
- R2: The step counter advances by one each cycle from 0. `t_line` is one-hot, with bit n set during step Tn.
- R3: At T0 with `irq` low, only `ar_ld_pc` is asserted. At T1 of a normal instruction, `mem_rd`, `ir_ld` and `pc_inc` are asserted together.
- R4: At T2, only `ar_ld_ir` is asserted. At most one address-register source strobe is ever high.
- R5: For operation codes 0 to 5: at T3, `ar_ld_mem` and `mem_rd` are asserted when `ind_bit` is 1 and nothing is asserted otherwise. At T4, `mem_rd` is asserted. At T5, `alu_go` and `sc_clr` are asserted.
- R6: For operation code 6, T3 behaves as in R5, and T4 asserts `mem_wr` with `sc_clr`.
- R7: For operation code 7, T3 asserts `sc_clr` whatever `ind_bit` is. It also asserts `pc_inc` when (instruction bit 1 and `flags[0]`) or (instruction bit 2 and `flags[1]`) holds. It sets the halt state when instruction bit 0 is 1.
- R8: In the cycle after `sc_clr`, the block is at T0 unless it has just halted.
- R9: When `irq` is high at T0, `int_ack` is asserted instead of `ar_ld_pc`. The next cycle asserts `pc_vec` and `sc_clr` with no fetch strobes. `irq` has no effect at any other step or while halted.
- R10: While halted, `halted` is 1, `t_line` is all zero, every strobe is low and the counter stays at 0.
- R11: `restart` while halted clears the halt state, and the next cycle is T0. `restart` while running has no effect.
- R12: A synchronous active-high `rst` clears the counter, the halt and interrupt states, the instruction register, `op_line` and `ind_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Memory read data, captured as the instruction at T1 |
| flags | input | 2 | Status flags: bit 0 accumulator zero, bit 1 accumulator negative |
| irq | input | 1 | Interrupt request, sampled at T0 |
| restart | input | 1 | Leaves the halt state |
| ar_ld_pc | output | 1 | Load address register from program counter |
| ar_ld_ir | output | 1 | Load address register from `addr_field` |
| ar_ld_mem | output | 1 | Load address register from memory (indirect) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_ld | output | 1 | Instruction register load (internal, also shown) |
| pc_inc | output | 1 | Program counter increment |
| pc_vec | output | 1 | Load program counter with the interrupt vector |
| int_ack | output | 1 | Interrupt accepted; save the program counter |
| alu_go | output | 1 | ALU operate on the fetched operand |
| sc_clr | output | 1 | Last step of the current cycle |
| halted | output | 1 | Halt state |
| t_line | output | 16 | One-hot timing lines T0..T15 |
| op_line | output | 8 | One-hot operation lines |
| ind_bit | output | 1 | Latched addressing-mode bit |
| addr_field | output | 12 | Address field of the instruction register |

## Verification
Strobes are decoded from registered state and are due in the same cycle as their timing step. `addr_field` changes one cycle after the T1 that captured the instruction. `op_line` and `ind_bit` change two cycles after that T1. `halted` rises one cycle after the halting T3 and falls one cycle after `restart`. The bench drives inputs just after a rising edge and compares every output half a period later, against a step-level model it advances only after the edge. Each comparison is therefore made against state that is already settled.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;
  // number of timing steps the control logic decodes
  localparam int unsigned SEQ_STEPS = 6;

  typedef struct packed {
    logic ar_ld_pc;
    logic ar_ld_ir;
    logic ar_ld_mem;
    logic mem_rd;
    logic mem_wr;
    logic ir_ld;
    logic pc_inc;
    logic pc_vec;
    logic int_ack;
    logic alu_go;
    logic sc_clr;
    logic halt_set;
  } strobe_t;
endpackage

// File: rtl/hwseq_timing.sv
module hwseq_timing #(
  parameter int SC_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hold,
  input  logic                   clr,
  output logic [(1<<SC_W)-1:0]   t_line
);
  localparam int N_T = 1 << SC_W;

  logic [SC_W-1:0] sc_q;

  // hold (halt) parks the counter at zero
  always_ff @(posedge clk) begin
    if (rst || hold || clr) sc_q <= '0;
    else                    sc_q <= sc_q + 1'b1;
  end

  for (genvar i = 0; i < N_T; i++) begin : g_tdec
    assign t_line[i] = !hold && (sc_q == SC_W'(i));
  end
endmodule

// File: rtl/hwseq_opdec.sv
module hwseq_opdec #(
  parameter int OPC_W = 3
) (
  input  logic [OPC_W-1:0]        sel,
  output logic [(1<<OPC_W)-1:0]   onehot
);
  for (genvar i = 0; i < (1 << OPC_W); i++) begin : g_odec
    assign onehot[i] = (sel == OPC_W'(i));
  end
endmodule

// File: rtl/hwseq_strobes.sv
module hwseq_strobes
  import hwseq_pkg::*;
#(
  parameter int N_OPS  = 8,
  parameter int FLAG_W = 2
) (
  input  logic [SEQ_STEPS-1:0] t,
  input  logic [N_OPS-1:0]     op,
  input  logic                 ind,
  input  logic [FLAG_W:0]      ctl,
  input  logic [FLAG_W-1:0]    flags,
  input  logic                 irq,
  input  logic                 int_q,
  output strobe_t              st
);
  localparam int REG_OP = N_OPS - 1;
  localparam int WR_OP  = N_OPS - 2;

  logic reg_grp, wr_grp, alu_grp, skip, fetch1, indir3;

  always_comb begin
    reg_grp = op[REG_OP];
    wr_grp  = op[WR_OP];
    alu_grp = |op[WR_OP-1:0];
    skip    = |(ctl[FLAG_W:1] & flags);
    fetch1  = t[1] && !int_q;
    indir3  = t[3] && !reg_grp && ind;

    st           = '0;
    st.int_ack   = t[0] && irq;
    st.ar_ld_pc  = t[0] && !irq;
    st.ir_ld     = fetch1;
    st.pc_vec    = t[1] && int_q;
    st.ar_ld_ir  = t[2];
    st.ar_ld_mem = indir3;
    st.mem_rd    = fetch1 || indir3 || (t[4] && alu_grp);
    st.pc_inc    = fetch1 || (t[3] && reg_grp && skip);
    st.halt_set  = t[3] && reg_grp && ctl[0];
    st.mem_wr    = t[4] && wr_grp;
    st.alu_go    = t[5] && alu_grp;
    st.sc_clr    = (t[1] && int_q) || (t[3] && reg_grp) ||
                   (t[4] && wr_grp) || (t[5] && alu_grp);
  end
endmodule

// File: rtl/hwseq_ctrl.sv
module hwseq_ctrl
  import hwseq_pkg::*;
#(
  parameter int IR_W   = 16,
  parameter int OPC_W  = 3,
  parameter int SC_W   = 4,
  parameter int FLAG_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IR_W-1:0]             mem_rdata,
  input  logic [FLAG_W-1:0]           flags,
  input  logic                        irq,
  input  logic                        restart,
  output logic                        ar_ld_pc,
  output logic                        ar_ld_ir,
  output logic                        ar_ld_mem,
  output logic                        mem_rd,
  output logic                        mem_wr,
  output logic                        ir_ld,
  output logic                        pc_inc,
  output logic                        pc_vec,
  output logic                        int_ack,
  output logic                        alu_go,
  output logic                        sc_clr,
  output logic                        halted,
  output logic [(1<<SC_W)-1:0]        t_line,
  output logic [(1<<OPC_W)-1:0]       op_line,
  output logic                        ind_bit,
  output logic [IR_W-OPC_W-2:0]       addr_field
);
  localparam int ADDR_W = IR_W - OPC_W - 1;
  localparam int N_OPS  = 1 << OPC_W;

  logic [IR_W-1:0]  ir_q;
  logic [N_OPS-1:0] op_q, dec_w;
  logic             ind_q, halt_q, int_q;
  strobe_t          st;

  hwseq_timing #(.SC_W(SC_W)) u_timing (
    .clk(clk), .rst(rst), .hold(halt_q), .clr(st.sc_clr), .t_line(t_line)
  );

  hwseq_opdec #(.OPC_W(OPC_W)) u_opdec (
    .sel(ir_q[IR_W-2 -: OPC_W]), .onehot(dec_w)
  );

  hwseq_strobes #(.N_OPS(N_OPS), .FLAG_W(FLAG_W)) u_strobes (
    .t(t_line[SEQ_STEPS-1:0]), .op(op_q), .ind(ind_q),
    .ctl(ir_q[FLAG_W:0]), .flags(flags), .irq(irq), .int_q(int_q), .st(st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= '0;
      op_q   <= '0;
      ind_q  <= 1'b0;
      halt_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      if (st.ir_ld) ir_q <= mem_rdata;
      if (st.ar_ld_ir) begin
        op_q  <= dec_w;
        ind_q <= ir_q[IR_W-1];
      end
      if (st.int_ack)     int_q <= 1'b1;
      else if (st.pc_vec) int_q <= 1'b0;
      if (st.halt_set)              halt_q <= 1'b1;
      else if (halt_q && restart)   halt_q <= 1'b0;
    end
  end

  assign ar_ld_pc   = st.ar_ld_pc;
  assign ar_ld_ir   = st.ar_ld_ir;
  assign ar_ld_mem  = st.ar_ld_mem;
  assign mem_rd     = st.mem_rd;
  assign mem_wr     = st.mem_wr;
  assign ir_ld      = st.ir_ld;
  assign pc_inc     = st.pc_inc;
  assign pc_vec     = st.pc_vec;
  assign int_ack    = st.int_ack;
  assign alu_go     = st.alu_go;
  assign sc_clr     = st.sc_clr;
  assign halted     = halt_q;
  assign op_line    = op_q;
  assign ind_bit    = ind_q;
  assign addr_field = ir_q[ADDR_W-1:0];
endmodule

// File: rtl/hwseq_ctrl_chk.sv
module hwseq_ctrl_chk #(
  parameter int IR_W  = 16,
  parameter int OPC_W = 3,
  parameter int SC_W  = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [IR_W-1:0]           mem_rdata,
  input logic                      irq,
  input logic                      restart,
  input logic                      ar_ld_pc,
  input logic                      ar_ld_ir,
  input logic                      ar_ld_mem,
  input logic                      mem_rd,
  input logic                      mem_wr,
  input logic                      ir_ld,
  input logic                      pc_inc,
  input logic                      pc_vec,
  input logic                      int_ack,
  input logic                      alu_go,
  input logic                      sc_clr,
  input logic                      halted,
  input logic [(1<<SC_W)-1:0]      t_line,
  input logic [(1<<OPC_W)-1:0]     op_line,
  input logic                      ind_bit,
  input logic [IR_W-OPC_W-2:0]     addr_field
);
  localparam int N_T    = 1 << SC_W;
  localparam int N_OPS  = 1 << OPC_W;
  localparam int ADDR_W = IR_W - OPC_W - 1;

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!halted && !sc_clr) |=> (t_line == ($past(t_line) << 1)));

  a_r8_clr_to_t0: assert property (@(posedge clk) disable iff (rst)
    sc_clr |=> (halted || t_line == N_T'(1)));

  a_r3_fetch_group: assert property (@(posedge clk) disable iff (rst)
    ir_ld |-> (mem_rd && pc_inc && t_line[1]));

  a_r4_ar_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ar_ld_pc, ar_ld_ir, ar_ld_mem}));

  a_r9_irq_take: assert property (@(posedge clk) disable iff (rst)
    (t_line[0] && irq) |-> (int_ack && !ar_ld_pc));

  a_r9_vector: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> (pc_vec && sc_clr && !ir_ld));

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (t_line == '0 && !(ar_ld_pc || ar_ld_ir || ar_ld_mem || mem_rd ||
                mem_wr || ir_ld || pc_inc || pc_vec || int_ack || alu_go || sc_clr)));

  a_r11_restart: assert property (@(posedge clk) disable iff (rst)
    (halted && restart) |=> (!halted && t_line == N_T'(1)));

  a_r6_write_last: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> sc_clr);

  a_r1_addr: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (addr_field == $past(mem_rdata[ADDR_W-1:0])));

  a_r1_decode: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> ##1 (op_line == (N_OPS'(1) << $past(mem_rdata[IR_W-2 -: OPC_W], 2)) &&
                   ind_bit == $past(mem_rdata[IR_W-1], 2)));
endmodule

bind hwseq_ctrl hwseq_ctrl_chk chk_i (.*);

// File: tb/hwseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwseq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  flags = '0;
  logic        irq = 1'b0, restart = 1'b0;
  logic ar_ld_pc, ar_ld_ir, ar_ld_mem, mem_rd, mem_wr, ir_ld, pc_inc, pc_vec;
  logic int_ack, alu_go, sc_clr, halted, ind_bit;
  logic [15:0] t_line;
  logic [7:0]  op_line;
  logic [11:0] addr_field;

  always #2 clk = ~clk; // 250 MHz

  hwseq_ctrl dut_i (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .flags(flags), .irq(irq),
    .restart(restart), .ar_ld_pc(ar_ld_pc), .ar_ld_ir(ar_ld_ir),
    .ar_ld_mem(ar_ld_mem), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
    .pc_inc(pc_inc), .pc_vec(pc_vec), .int_ack(int_ack), .alu_go(alu_go),
    .sc_clr(sc_clr), .halted(halted), .t_line(t_line), .op_line(op_line),
    .ind_bit(ind_bit), .addr_field(addr_field)
  );

  localparam int P_ARPC = 10, P_ARIR = 9, P_ARM = 8, P_RD = 7, P_WR = 6,
                 P_IRLD = 5, P_PCI = 4, P_VEC = 3, P_ACK = 2, P_ALU = 1, P_CLR = 0;

  int n_chk = 0, n_fail = 0;

  // reference model state
  bit          m_valid = 0, m_halt = 0, m_int = 0, m_ind = 0;
  int          m_sc = 0;
  logic [15:0] m_ir = '0;
  logic [7:0]  m_op = '0;
  bit          m_rst_tag = 0, m_after_clr = 0, m_after_rs = 0;

  function automatic logic [10:0] exp_str(logic [1:0] flg, bit irqv);
    logic [10:0] r = '0;
    if (m_halt) return r;
    case (m_sc)
      0: if (irqv) r[P_ACK] = 1; else r[P_ARPC] = 1;
      1: if (m_int) begin r[P_VEC] = 1; r[P_CLR] = 1; end
         else begin r[P_RD] = 1; r[P_IRLD] = 1; r[P_PCI] = 1; end
      2: r[P_ARIR] = 1;
      3: if (m_op[7]) begin
           r[P_CLR] = 1;
           if ((m_ir[1] && flg[0]) || (m_ir[2] && flg[1])) r[P_PCI] = 1;
         end else if (m_ind) begin r[P_ARM] = 1; r[P_RD] = 1; end
      4: if (m_op[6]) begin r[P_WR] = 1; r[P_CLR] = 1; end else r[P_RD] = 1;
      5: begin r[P_ALU] = 1; r[P_CLR] = 1; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic string str_tag(bit irqv);
    if (m_halt) return "R10";
    case (m_sc)
      0: return irqv ? "R9" : "R3";
      1: return m_int ? "R9" : "R3";
      2: return "R4";
      default: return m_op[7] ? "R7" : (m_op[6] ? "R6" : "R5");
    endcase
  endfunction

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
    end
  endtask

  task automatic cycle(logic [15:0] mem, logic [1:0] flg, bit irq_i, bit rst_i, bit rs_i);
    logic [10:0] es;
    string st_tg, tag_tl;
    int old_sc;
    mem_rdata = mem; flags = flg; irq = irq_i; rst = rst_i; restart = rs_i;
    #1;
    es = exp_str(flg, irq_i);
    if (m_valid) begin
      st_tg = str_tag(irq_i);
      tag_tl = m_rst_tag ? "R12" : m_after_rs ? "R11" : m_after_clr ? "R8" :
               m_halt ? "R10" : "R2";
      chk(st_tg, "strobes", {ar_ld_pc, ar_ld_ir, ar_ld_mem, mem_rd, mem_wr, ir_ld,
                             pc_inc, pc_vec, int_ack, alu_go, sc_clr}, es);
      chk(tag_tl, "t_line", t_line, m_halt ? 16'd0 : (16'd1 << m_sc));
      chk(tag_tl, "halted", halted, m_halt);
      chk(m_rst_tag ? "R12" : "R1", "op_line/ind", {op_line, ind_bit}, {m_op, m_ind});
      chk(m_rst_tag ? "R12" : "R1", "addr_field", addr_field, m_ir[11:0]);
    end
    @(posedge clk); #1;
    m_rst_tag = 0; m_after_clr = 0; m_after_rs = 0;
    if (rst_i) begin
      m_valid = 1; m_halt = 0; m_int = 0; m_ind = 0; m_sc = 0;
      m_ir = '0; m_op = '0; m_rst_tag = 1;
    end else if (m_valid) begin
      if (m_halt) begin
        if (rs_i) begin m_halt = 0; m_after_rs = 1; end
      end else begin
        old_sc = m_sc;
        if (es[P_CLR]) begin m_sc = 0; m_after_clr = 1; end else m_sc++;
        if (es[P_ACK]) m_int = 1; else if (es[P_VEC]) m_int = 0;
        if (old_sc == 3 && m_op[7] && m_ir[0]) m_halt = 1;
        if (old_sc == 2) begin m_op = 8'd1 << m_ir[14:12]; m_ind = m_ir[15]; end
        if (es[P_IRLD]) m_ir = mem;
      end
    end
  endtask

  // one instruction from T0; random irq / restart inside (R9, R11 ignore cases)
  task automatic exec_instr(logic [15:0] ins, bit take_irq, logic [1:0] flg);
    int guard = 0;
    cycle($urandom, flg, take_irq, 0, 0);
    while (m_sc != 0 && !m_halt && guard < 20) begin
      cycle((m_sc == 1) ? ins : 16'($urandom), flg, 1'($urandom), 0, 1'($urandom));
      guard++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1;
    // R12 reset, checked in the first cycle after it
    repeat (3) cycle($urandom, 2'b11, 1, 1, 1);
    exec_instr(16'h0123, 0, 2'b00);   // R5 direct
    exec_instr(16'hB456, 0, 2'b00);   // R5 indirect
    exec_instr(16'hE010, 0, 2'b00);   // R6 indirect store
    exec_instr(16'h6010, 0, 2'b00);   // R6 direct
    exec_instr(16'h7002, 0, 2'b01);   // R7 skip on zero
    exec_instr(16'h7002, 0, 2'b10);   // R7 no skip
    exec_instr(16'h7004, 0, 2'b10);   // R7 skip on negative
    exec_instr(16'hF000, 0, 2'b11);   // R7 indirect bit ignored
    exec_instr(16'h0000, 1, 2'b00);   // R9 interrupt entry
    exec_instr(16'h2FFF, 0, 2'b00);   // R8 fetch after interrupt
    exec_instr(16'h7001, 0, 2'b00);   // R7 halt
    repeat (5) cycle($urandom, 2'b11, 1, 0, 0); // R10 irq ignored while halted
    cycle($urandom, 2'b00, 0, 0, 1);  // R11 restart
    exec_instr(16'h1ABC, 0, 2'b00);
    cycle($urandom, 0, 0, 0, 0);      // mid-instruction reset, R12
    cycle($urandom, 0, 0, 0, 0);
    cycle($urandom, 0, 0, 1, 0);
    exec_instr(16'h5555, 0, 2'b00);
    for (int i = 0; i < 500; i++) begin
      if (m_halt) begin
        repeat (1 + $urandom % 3) cycle($urandom, 2'($urandom), 1'($urandom), 0, 0);
        cycle($urandom, 2'($urandom), 1'($urandom), 0, 1);
      end else if ($urandom % 60 == 0) begin
        cycle($urandom, 2'($urandom), 1'($urandom), 1, 1'($urandom));
      end else begin
        exec_instr(16'($urandom), ($urandom % 8 == 0), 2'($urandom));
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule